// File: doc/BRIEF.md
# Staged Multi-Channel DAC Code Register Front End

This block sits between a byte-wide write bus and an eight-channel, 12-bit digital-to-analog converter. Software builds a 12-bit code from two byte writes, a low byte and a high nibble. The write of the high part places the code in the holding register of the currently selected channel. That channel is then flagged as pending. Channel selection is a separate control write.

Nothing reaches the converter-facing output registers until an update command is written. That command moves every pending channel to its output register on one clock edge, so several channels change together. A second path keeps a preset code that is captured from the data registers. A command forces that code onto all eight outputs at once. The usual preset is 0 for a unipolar output at 0 V, or 2048 for a bipolar output at 0 V.

The write interface is a plain strobe. There is no valid/ready handshake, because the block accepts a write on every cycle and never back-pressures. Every output register is presented in parallel. A one-cycle pulse marks the cycle in which new output values first appear.

Top module: `dac_stage_top`

## Requirements
- R1: After synchronous reset (`rst` high at a clock edge), all eight output codes read 0 and `commit_pulse` is 0.
- R2: A write to address 1 commits the 12-bit word {wr_data[3:0], last byte written to address 0} into the holding register of the selected channel. The output codes do not change on that write.
- R3: A write to address 2 with bit 3 set copies every pending channel's holding value to its output register on the same edge. Channels that are not pending keep their output value.
- R4: When a write to address 2 has bit 3 set, bits 2:0 of that write are ignored and the channel selection is left unchanged.
- R5: The update clears all pending flags, so a following update with no new data writes changes no output.
- R6: A write to address 3 with bit 0 set copies {last high nibble written to address 1, last byte written to address 0} into the preset register.
- R7: A write to address 3 with bit 1 set loads the preset register into all eight output registers and clears all pending flags. If bits 0 and 1 are both set, the apply uses the preset value held before that write.
- R8: `commit_pulse` is high for exactly the one cycle in which the outputs of an update or a preset apply first appear, and low otherwise.
- R9: A second data commit to the same channel before an update replaces the first, and the later word is the one that is output.
- R10: A write to address 2 with bit 3 clear selects channel wr_data[2:0] for later data commits. Channel n occupies dac_codes[12n+11:12n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 2 | Register address: 0 low byte, 1 high nibble, 2 channel/update, 3 preset command |
| wr_data | input | 8 | Write data byte |
| dac_codes | output | 96 | Eight 12-bit output codes; channel n at bits 12n+11:12n |
| commit_pulse | output | 1 | One-cycle marker that new output values are present |

## Verification
A stale pending flag shows up as an output that changes on an update when it should hold, or as a second update that moves a channel. Both are visible at `dac_codes` on the cycle after the update write. A wrong channel selection, or a wrongly kept low byte, shows up only when the next update commits a code to the wrong slot or with the wrong value. The bench therefore checks every output after each write, so that such errors are caught within one update of their cause. A bad preset register is exposed on the first apply after it is loaded.

// File: rtl/dac_stage_pkg.sv
package dac_stage_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_LO   = 2'd0,
    REG_HI   = 2'd1,
    REG_CTRL = 2'd2,
    REG_CMD  = 2'd3
  } reg_sel_e;

  localparam int CMD_PLOAD_BIT  = 0;
  localparam int CMD_PAPPLY_BIT = 1;
endpackage

// File: rtl/dac_stage_decode.sv
module dac_stage_decode
  import dac_stage_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int CH_N   = 8,
  localparam int SEL_W = $clog2(CH_N),
  localparam int HI_W  = CODE_W - BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [BYTE_W-1:0]    wr_data,
  output logic [SEL_W-1:0]     sel_q,
  output logic [CODE_W-1:0]    data_word,
  output logic [CODE_W-1:0]    commit_word,
  output logic                 commit_en,
  output logic                 upd_cmd,
  output logic                 pload_cmd,
  output logic                 papply_cmd
);
  logic [BYTE_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic              hit_lo, hit_hi, hit_ctrl, hit_cmd;

  always_comb begin
    hit_lo   = wr_en && (wr_addr == REG_LO);
    hit_hi   = wr_en && (wr_addr == REG_HI);
    hit_ctrl = wr_en && (wr_addr == REG_CTRL);
    hit_cmd  = wr_en && (wr_addr == REG_CMD);
    upd_cmd    = hit_ctrl && wr_data[SEL_W];
    pload_cmd  = hit_cmd && wr_data[CMD_PLOAD_BIT];
    papply_cmd = hit_cmd && wr_data[CMD_PAPPLY_BIT];
    commit_en   = hit_hi;
    commit_word = {wr_data[HI_W-1:0], lo_q};
    data_word   = {hi_q, lo_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q  <= '0;
      hi_q  <= '0;
      sel_q <= '0;
    end else begin
      if (hit_lo) lo_q <= wr_data;
      if (hit_hi) hi_q <= wr_data[HI_W-1:0];
      if (hit_ctrl && !wr_data[SEL_W]) sel_q <= wr_data[SEL_W-1:0];
    end
  end

  assert_sel_keep_R4: assert property (@(posedge clk) disable iff (rst)
    upd_cmd |=> $stable(sel_q));
  assert_lo_keep_R6: assert property (@(posedge clk) disable iff (rst)
    !hit_lo |=> $stable(lo_q));
endmodule

// File: rtl/dac_stage_slot.sv
module dac_stage_slot #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_en,
  input  logic [CODE_W-1:0] commit_word,
  input  logic              upd_cmd,
  input  logic              papply_cmd,
  input  logic [CODE_W-1:0] preset,
  output logic [CODE_W-1:0] out_q
);
  logic [CODE_W-1:0] hold_q;
  logic              pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      pend_q <= 1'b0;
      out_q  <= '0;
    end else begin
      if (commit_en) hold_q <= commit_word;
      if (upd_cmd || papply_cmd) pend_q <= 1'b0;
      else if (commit_en)        pend_q <= 1'b1;
      if (papply_cmd)                out_q <= preset;
      else if (upd_cmd && pend_q)    out_q <= hold_q;
    end
  end

  assert_out_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!(upd_cmd && pend_q) && !papply_cmd) |=> $stable(out_q));
  assert_pend_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_cmd || papply_cmd) |=> !pend_q);
  assert_apply_R7: assert property (@(posedge clk) disable iff (rst)
    papply_cmd |=> (out_q == $past(preset)));
  assert_commit_R2: assert property (@(posedge clk) disable iff (rst)
    (commit_en && !upd_cmd && !papply_cmd) |=> (pend_q && hold_q == $past(commit_word)));
endmodule

// File: rtl/dac_stage_top.sv
module dac_stage_top
  import dac_stage_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int CH_N   = 8,
  localparam int SEL_W = $clog2(CH_N)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [1:0]             wr_addr,
  input  logic [7:0]             wr_data,
  output logic [CH_N*CODE_W-1:0] dac_codes,
  output logic                   commit_pulse
);
  logic [SEL_W-1:0]  sel_q;
  logic [CODE_W-1:0] data_word, commit_word, preset_q;
  logic              commit_en, upd_cmd, pload_cmd, papply_cmd;

  dac_stage_decode #(.CODE_W(CODE_W), .CH_N(CH_N)) u_decode (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sel_q(sel_q), .data_word(data_word), .commit_word(commit_word),
    .commit_en(commit_en), .upd_cmd(upd_cmd), .pload_cmd(pload_cmd),
    .papply_cmd(papply_cmd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      preset_q     <= '0;
      commit_pulse <= 1'b0;
    end else begin
      if (pload_cmd) preset_q <= data_word;
      commit_pulse <= upd_cmd || papply_cmd;
    end
  end

  for (genvar i = 0; i < CH_N; i++) begin : g_slot
    dac_stage_slot #(.CODE_W(CODE_W)) u_slot (
      .clk(clk), .rst(rst),
      .commit_en(commit_en && (sel_q == SEL_W'(i))),
      .commit_word(commit_word),
      .upd_cmd(upd_cmd), .papply_cmd(papply_cmd), .preset(preset_q),
      .out_q(dac_codes[i*CODE_W +: CODE_W])
    );
  end

  assert_pulse_on_R8: assert property (@(posedge clk) disable iff (rst)
    (upd_cmd || papply_cmd) |=> commit_pulse);
  assert_pulse_off_R8: assert property (@(posedge clk) disable iff (rst)
    !(upd_cmd || papply_cmd) |=> !commit_pulse);
  assert_preset_keep_R6: assert property (@(posedge clk) disable iff (rst)
    !pload_cmd |=> $stable(preset_q));
endmodule

// File: tb/dac_stage_top_bench.sv
module dac_stage_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [95:0] dac_codes;
  logic        commit_pulse;

  int vectors = 0;
  int errors  = 0;

  logic [7:0]  m_lo;
  logic [3:0]  m_hi;
  logic [2:0]  m_sel;
  logic [11:0] m_hold [8];
  logic        m_pend [8];
  logic [11:0] m_out  [8];
  logic [11:0] m_preset;
  logic        m_pulse;

  always #4 clk = ~clk;

  dac_stage_top u_dac_stage_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dac_codes(dac_codes), .commit_pulse(commit_pulse)
  );

  function automatic logic [11:0] chan_of(input logic [95:0] v, input int n);
    return v[n*12 +: 12];
  endfunction

  task automatic model_write(input logic [1:0] a, input logic [7:0] d);
    m_pulse = 1'b0;
    case (a)
      2'd0: m_lo = d;
      2'd1: begin
        m_hi = d[3:0];
        m_hold[m_sel] = {d[3:0], m_lo};
        m_pend[m_sel] = 1'b1;
      end
      2'd2: begin
        if (d[3]) begin
          for (int i = 0; i < 8; i++) begin
            if (m_pend[i]) m_out[i] = m_hold[i];
            m_pend[i] = 1'b0;
          end
          m_pulse = 1'b1;
        end else m_sel = d[2:0];
      end
      default: begin
        logic [11:0] old_p;
        old_p = m_preset;
        if (d[0]) m_preset = {m_hi, m_lo};
        if (d[1]) begin
          for (int i = 0; i < 8; i++) begin
            m_out[i] = old_p;
            m_pend[i] = 1'b0;
          end
          m_pulse = 1'b1;
        end
      end
    endcase
  endtask

  task automatic check_all(input string req);
    vectors++;
    for (int i = 0; i < 8; i++) begin
      if (chan_of(dac_codes, i) !== m_out[i]) begin
        errors++;
        $display("FAIL %s ch%0d actual %0d expected %0d", req, i, chan_of(dac_codes, i), m_out[i]);
      end
    end
    vectors++;
    if (commit_pulse !== m_pulse) begin
      errors++;
      $display("FAIL R8 pulse actual %0b expected %0b (%s)", commit_pulse, m_pulse, req);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    model_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
    check_all(req);
    m_pulse = 1'b0;
  endtask

  task automatic set_code(input int ch, input logic [11:0] c, input string req);
    do_wr(2'd2, {5'd0, 3'(ch)}, "R10");
    do_wr(2'd0, c[7:0], req);
    do_wr(2'd1, {4'd0, c[11:8]}, "R2");
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    m_lo = '0; m_hi = '0; m_sel = '0; m_preset = '0; m_pulse = 1'b0;
    for (int i = 0; i < 8; i++) begin m_hold[i] = '0; m_pend[i] = 1'b0; m_out[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R1");

    // R2/R10/R3: stage two channels, outputs held until update
    set_code(3, 12'hABC, "R2");
    set_code(6, 12'h123, "R10");
    do_wr(2'd2, 8'h08, "R3");
    // R5: second update with no data writes changes nothing
    do_wr(2'd2, 8'h08, "R5");
    // R4: update with channel bits set, then commit lands on channel 6
    do_wr(2'd2, 8'h0F, "R4");
    do_wr(2'd0, 8'h55, "R4");
    do_wr(2'd1, 8'h07, "R4");
    do_wr(2'd2, 8'h08, "R4");
    // R9: overwrite before update
    set_code(1, 12'h111, "R9");
    set_code(1, 12'hFEE, "R9");
    do_wr(2'd2, 8'h08, "R9");
    // R6/R7: bipolar mid-scale preset
    do_wr(2'd0, 8'h00, "R6");
    do_wr(2'd1, 8'h08, "R6");
    do_wr(2'd3, 8'h01, "R6");
    set_code(2, 12'h333, "R7");
    do_wr(2'd3, 8'h02, "R7");
    do_wr(2'd2, 8'h08, "R7");
    // R7: load and apply together use the old preset
    do_wr(2'd0, 8'h00, "R7");
    do_wr(2'd1, 8'h00, "R7");
    do_wr(2'd3, 8'h03, "R7");
    do_wr(2'd3, 8'h02, "R7");

    for (int k = 0; k < 600; k++) begin
      int r;
      r = int'($urandom % 10);
      if (r < 3)       do_wr(2'd0, 8'($urandom), "R2");
      else if (r < 6)  do_wr(2'd1, 8'($urandom), "R2");
      else if (r < 8)  do_wr(2'd2, 8'($urandom) & 8'h0F, "R3");
      else             do_wr(2'd3, 8'($urandom) & 8'h03, "R7");
    end

    // R1: reset in mid-operation
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_lo = '0; m_hi = '0; m_sel = '0; m_preset = '0; m_pulse = 1'b0;
    for (int i = 0; i < 8; i++) begin m_hold[i] = '0; m_pend[i] = 1'b0; m_out[i] = '0; end
    check_all("R1");
    do_wr(2'd2, 8'h08, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule